// File: doc/BRIEF.md
# Floppy Controller Host Transfer Interface

This block is the processor-facing half of a floppy disk controller. The host uses chip select, read and write strobes and one address bit to reach two registers over an 8-bit bus. One is a read-only status register that tells the host when it may touch the data register and in which direction. The other is the data register, which carries command bytes in, transfer bytes both ways, and result bytes out.

A small phase sequencer stub drives the interface through three phases: command, execution and result. During execution a byte falls due once every `BYTE_TIME` clock cycles, which stands in for the serial rate of the media side. The host moves each byte in one of two ways. In interrupt mode the host is interrupted for every byte and accesses the data register with chip select. In DMA mode a request/acknowledge handshake is used, and the acknowledge alone selects the data register. A terminal count pulse given with a byte access ends the transfer after that byte. If a byte is not serviced before the next one falls due, the overrun flag is set and the sequencer goes straight to the result phase. This also applies to the final byte of a sector. The DMA request is dropped before any result byte becomes readable.

Top module: `fdc_host_if`

## Requirements
- R1: With `a0` high the data register is accessed, and with `a0` low the status register is read. Status bit 7 means the data register is ready for the host. Bit 6 gives the direction, 1 for controller to host. Bit 5 marks execution in interrupt mode. Bit 4 means busy, which covers a command in progress or any phase other than idle command. Bits 3:0 read 0, so idle status is 0x80.
- R2: `dbus_oe` is high only while `rd_n` is low and either `cs_n` or `dack_n` is low. A write while `cs_n` and `dack_n` are both high has no effect. A write to the status register (`a0` low, no acknowledge) has no effect.
- R3: In DMA-mode execution, `drq` is high while a byte is waiting. A read or write strobe with `dack_n` low accesses the data register without chip select, whatever the value of `a0`.
- R4: Command byte 0 is laid out as follows: bit 7 is the direction (1 moves disk data to the host), bit 6 enables DMA mode, and bits 5:0 hold the opcode. Opcode 0x08 is the sense-interrupt command, which takes one byte. Any other opcode takes a second byte N and moves N+1 bytes. The k-th byte read from the disk side has the value k XOR 0xA5.
- R5: The first byte becomes available (read) or is requested (write) exactly `BYTE_TIME` cycles after the clock edge that accepts the second command byte. Each later byte follows `BYTE_TIME` cycles after the previous one.
- R6: When `tc` is high during a serviced data access in execution, the transfer ends after that byte and ST0 reads 0x00.
- R7: A byte still unserviced when the next byte falls due ends execution at once. ST0 then reads 0x40 and ST1 bit 4 is set. This includes the final byte.
- R8: The result phase returns four bytes in order: ST0, ST1, the count of bytes moved, and the XOR of all bytes moved. Status reads 0xD0 during the result phase and 0x80 after the fourth byte has been read.
- R9: `drq` is low from the first cycle of the result phase onward, even if no acknowledge ever arrives.
- R10: In interrupt mode, `irq` is high while a byte waits. In DMA mode, `irq` stays low during execution. In both modes, `irq` rises when a transfer command ends and is cleared by the host's read of the first result byte.
- R11: After reset, `irq`, `drq` and `dbus_oe` are low and status reads 0x80. If `drv_ready` is high during reset, `irq` rises `READY_WAIT` cycles after reset is released. A sense command clears that interrupt and returns 0xC0, 0, 0, 0. When nothing is pending it returns 0x80, 0, 0, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| a0 | input | 1 | Register select: 1 data, 0 status |
| dack_n | input | 1 | DMA acknowledge, active low |
| tc | input | 1 | Terminal count, sampled during a data access |
| dbus_i | input | 8 | Bus data from the host |
| dbus_o | output | 8 | Bus data to the host |
| dbus_oe | output | 1 | Bus output enable |
| drq | output | 1 | DMA request |
| irq | output | 1 | Interrupt request |
| drv_ready | input | 1 | Drive ready level, sampled during reset |

## Verification
The bench builds the block with `BYTE_TIME` = 40 and `READY_WAIT` = 60. With these values the ready interrupt delay, each byte window and each overrun fit in a few dozen cycles. The bench can therefore sweep transfer lengths 1 to 4 across both directions and both transfer modes, and compute the expected data and XOR sums arithmetically. The short windows also allow a cycle-exact check of when the first DMA request appears. They let the bench starve the final byte, stop a transfer part way with terminal count, and check the ready interrupt delay on both sides of its edge.

// File: rtl/fdc_host_pkg.sv
// Shared constants and types for the floppy controller host interface.
// Assumes an 8-bit host bus and a four-byte result phase.
package fdc_host_pkg;
    localparam int BUS_W     = 8;
    localparam int RES_BYTES = 4;
    // status register bit positions
    localparam int SB_RQM = 7;
    localparam int SB_DIO = 6;
    localparam int SB_EXM = 5;
    localparam int SB_BSY = 4;
    // command byte 0 fields
    localparam int CB_DIR = 7;
    localparam int CB_DMA = 6;
    localparam logic [5:0] OP_SENSE = 6'h08;
    // result encodings
    localparam int ST1_OVR = 4;
    localparam logic [BUS_W-1:0] ST0_OK      = 8'h00;
    localparam logic [BUS_W-1:0] ST0_ABORT   = 8'h40;
    localparam logic [BUS_W-1:0] ST0_RDYCHG  = 8'hC0;
    localparam logic [BUS_W-1:0] ST0_NOTHING = 8'h80;
    localparam logic [BUS_W-1:0] RD_PATTERN  = 8'hA5;

    typedef enum logic [1:0] {PH_CMD, PH_EXEC, PH_RES} phase_t;
endpackage

// File: rtl/fdc_bus_decode.sv
// Host bus decoder: qualifies strobes with chip select or DMA acknowledge
// and turns the end of each data access into a one-cycle pulse.
// Assumes bus inputs are already synchronous to clk.
module fdc_bus_decode import fdc_host_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             a0,
    input  logic             dack_n,
    input  logic             tc,
    input  logic [BUS_W-1:0] dbus_i,
    output logic             rd_act,
    output logic             rd_data_sel,
    output logic             rd_pop,
    output logic             wr_push,
    output logic [BUS_W-1:0] wr_byte,
    output logic             svc_tc
);
    logic wr_act;
    logic rd_q, wr_q, rsel_q, tc_hold;

    // Decode live strobes; status-register writes are dropped here.
    always_comb begin
        rd_act      = !rd_n && (!cs_n || !dack_n);
        rd_data_sel = !dack_n || a0;
        wr_act      = !wr_n && (!cs_n || !dack_n) && (!dack_n || a0);
        rd_pop      = rd_q && !rd_act && rsel_q;
        wr_push     = wr_q && !wr_act;
        svc_tc      = tc_hold;
    end

    // Remember strobe state, selected register, written byte and TC seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
            rsel_q  <= 1'b0;
            tc_hold <= 1'b0;
            wr_byte <= '0;
        end else begin
            rd_q    <= rd_act;
            wr_q    <= wr_act;
            if (rd_act) rsel_q <= rd_data_sel;
            if (wr_act) wr_byte <= dbus_i;
            tc_hold <= (rd_act || wr_act) ? (tc_hold || tc) : 1'b0;
        end
    end

    assert_one_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop || wr_push) |=> !(rd_pop || wr_push));
endmodule

// File: rtl/fdc_phase_seq.sv
// Command/execution/result sequencer stub with byte pacing, overrun and
// terminal count handling. Assumes one byte falls due every BYTE_TIME
// cycles during execution (BYTE_TIME >= 2).
module fdc_phase_seq import fdc_host_pkg::*; #(
    parameter int BYTE_TIME = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_pop,
    input  logic             wr_push,
    input  logic [BUS_W-1:0] wr_byte,
    input  logic             svc_tc,
    input  logic             rdy_pending,
    output phase_t           phase,
    output logic [BUS_W-1:0] status,
    output logic [BUS_W-1:0] data_out,
    output logic             drq,
    output logic             byte_irq,
    output logic             res_entry,
    output logic             res_first_pop,
    output logic             sense_hit
);
    localparam int CW  = BUS_W + 1;
    localparam int TW  = (BYTE_TIME > 1) ? $clog2(BYTE_TIME) : 1;
    localparam int RIW = $clog2(RES_BYTES);

    logic             cmd_idx, dir_rd, dma, pend, ovr;
    logic [CW-1:0]    total, xfer, nxt_idx;
    logic [BUS_W-1:0] sum, data_reg, st0, res_byte;
    logic [TW-1:0]    timer;
    logic [RIW-1:0]   ridx;
    logic             tick, svc_ok, last, ovr_hit;

    // Byte pacing, service and termination decisions.
    always_comb begin
        tick          = (phase == PH_EXEC) && (timer == TW'(BYTE_TIME - 1));
        svc_ok        = (phase == PH_EXEC) && pend && (dir_rd ? rd_pop : wr_push);
        last          = svc_ok && (svc_tc || ((xfer + 1'b1) == total));
        ovr_hit       = tick && pend && !svc_ok;
        nxt_idx       = svc_ok ? (xfer + 1'b1) : xfer;
        res_entry     = last || ovr_hit;
        sense_hit     = (phase == PH_CMD) && !cmd_idx && wr_push && (wr_byte[5:0] == OP_SENSE);
        res_first_pop = (phase == PH_RES) && (ridx == '0) && rd_pop;
    end

    // Status register and request outputs from the current phase.
    always_comb begin
        status         = '0;
        status[SB_RQM] = (phase == PH_CMD) || (phase == PH_RES) ||
                         ((phase == PH_EXEC) && !dma && pend);
        status[SB_DIO] = (phase == PH_RES) || ((phase == PH_EXEC) && dir_rd);
        status[SB_EXM] = (phase == PH_EXEC) && !dma;
        status[SB_BSY] = (phase != PH_CMD) || cmd_idx;
        drq            = (phase == PH_EXEC) && dma && pend;
        byte_irq       = (phase == PH_EXEC) && !dma && pend;
    end

    // Result byte selection and data register view.
    always_comb begin
        res_byte = '0;
        case (ridx)
            RIW'(0): res_byte = st0;
            RIW'(1): res_byte[ST1_OVR] = ovr;
            RIW'(2): res_byte = xfer[BUS_W-1:0];
            default: res_byte = sum;
        endcase
        data_out = (phase == PH_RES) ? res_byte : data_reg;
    end

    // Phase state machine with transfer bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_CMD;
            cmd_idx  <= 1'b0;
            dir_rd   <= 1'b0;
            dma      <= 1'b0;
            total    <= '0;
            xfer     <= '0;
            sum      <= '0;
            data_reg <= '0;
            st0      <= '0;
            pend     <= 1'b0;
            ovr      <= 1'b0;
            timer    <= '0;
            ridx     <= '0;
        end else begin
            case (phase)
                PH_CMD: if (wr_push) begin
                    if (!cmd_idx) begin
                        dir_rd <= wr_byte[CB_DIR];
                        dma    <= wr_byte[CB_DMA];
                        if (sense_hit) begin
                            phase <= PH_RES;
                            st0   <= rdy_pending ? ST0_RDYCHG : ST0_NOTHING;
                            ovr   <= 1'b0;
                            xfer  <= '0;
                            sum   <= '0;
                            ridx  <= '0;
                        end else begin
                            cmd_idx <= 1'b1;
                        end
                    end else begin
                        cmd_idx <= 1'b0;
                        total   <= {1'b0, wr_byte} + 1'b1;
                        phase   <= PH_EXEC;
                        timer   <= '0;
                        xfer    <= '0;
                        sum     <= '0;
                        pend    <= 1'b0;
                        ovr     <= 1'b0;
                    end
                end
                PH_EXEC: begin
                    timer <= tick ? '0 : timer + 1'b1;
                    if (svc_ok) begin
                        xfer <= xfer + 1'b1;
                        sum  <= sum ^ (dir_rd ? data_reg : wr_byte);
                    end
                    if (last) begin
                        phase <= PH_RES;
                        pend  <= 1'b0;
                        st0   <= ST0_OK;
                        ridx  <= '0;
                    end else if (ovr_hit) begin
                        phase <= PH_RES;
                        pend  <= 1'b0;
                        ovr   <= 1'b1;
                        st0   <= ST0_ABORT;
                        ridx  <= '0;
                    end else if (tick) begin
                        pend <= 1'b1;
                        if (dir_rd) data_reg <= nxt_idx[BUS_W-1:0] ^ RD_PATTERN;
                    end else if (svc_ok) begin
                        pend <= 1'b0;
                    end
                end
                PH_RES: if (rd_pop) begin
                    if (ridx == RIW'(RES_BYTES - 1)) begin
                        phase <= PH_CMD;
                        ridx  <= '0;
                    end else begin
                        ridx <= ridx + 1'b1;
                    end
                end
                default: phase <= PH_CMD;
            endcase
        end
    end

    assert_overrun_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_hit |=> (phase == PH_RES && ovr));
    assert_tc_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_ok && svc_tc) |=> (phase == PH_RES && !ovr));
    assert_drq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_entry |=> (!drq && status[SB_RQM]));
endmodule

// File: rtl/fdc_irq_ctl.sv
// Interrupt combiner: per-byte request, command-finished latch and the
// ready-at-reset latch. Assumes drv_ready is sampled while reset is held.
module fdc_irq_ctl #(
    parameter int READY_WAIT = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_ready,
    input  logic byte_irq,
    input  logic res_entry,
    input  logic res_first_pop,
    input  logic sense_hit,
    output logic irq,
    output logic rdy_pending
);
    localparam int RW = $clog2(READY_WAIT + 1);

    logic          arm, rdy_q, done_q;
    logic [RW-1:0] cnt;

    // Ready-delay counter and the two interrupt latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm    <= drv_ready;
            cnt    <= '0;
            rdy_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (arm) begin
                if (cnt == RW'(READY_WAIT - 1)) begin
                    rdy_q <= 1'b1;
                    arm   <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            if (sense_hit) rdy_q <= 1'b0;
            if (res_entry) done_q <= 1'b1;
            else if (res_first_pop) done_q <= 1'b0;
        end
    end

    // Combined request to the host.
    always_comb begin
        irq         = byte_irq || done_q || rdy_q;
        rdy_pending = rdy_q;
    end

    assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_first_pop && !res_entry) |=> !done_q);
    assert_sense_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_hit && !arm) |=> !rdy_q);
endmodule

// File: rtl/fdc_host_if.sv
// Top of the floppy controller host interface: bus decode, phase
// sequencer stub and interrupt control. Assumes synchronous bus inputs.
module fdc_host_if import fdc_host_pkg::*; #(
    parameter int BYTE_TIME  = 256,
    parameter int READY_WAIT = 8192
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic       a0,
    input  logic       dack_n,
    input  logic       tc,
    input  logic [7:0] dbus_i,
    output logic [7:0] dbus_o,
    output logic       dbus_oe,
    output logic       drq,
    output logic       irq,
    input  logic       drv_ready
);
    logic             rd_act, rd_data_sel, rd_pop, wr_push, svc_tc;
    logic [BUS_W-1:0] wr_byte, status, data_out;
    phase_t           phase;
    logic             byte_irq, res_entry, res_first_pop, sense_hit, rdy_pending;

    fdc_bus_decode u_dec (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .a0(a0), .dack_n(dack_n), .tc(tc), .dbus_i(dbus_i),
        .rd_act(rd_act), .rd_data_sel(rd_data_sel), .rd_pop(rd_pop),
        .wr_push(wr_push), .wr_byte(wr_byte), .svc_tc(svc_tc)
    );

    fdc_phase_seq #(.BYTE_TIME(BYTE_TIME)) u_seq (
        .clk(clk), .rst_n(rst_n), .rd_pop(rd_pop), .wr_push(wr_push),
        .wr_byte(wr_byte), .svc_tc(svc_tc), .rdy_pending(rdy_pending),
        .phase(phase), .status(status), .data_out(data_out), .drq(drq),
        .byte_irq(byte_irq), .res_entry(res_entry),
        .res_first_pop(res_first_pop), .sense_hit(sense_hit)
    );

    fdc_irq_ctl #(.READY_WAIT(READY_WAIT)) u_irq (
        .clk(clk), .rst_n(rst_n), .drv_ready(drv_ready), .byte_irq(byte_irq),
        .res_entry(res_entry), .res_first_pop(res_first_pop),
        .sense_hit(sense_hit), .irq(irq), .rdy_pending(rdy_pending)
    );

    // Bus read mux between data and status registers.
    always_comb begin
        dbus_oe = rd_act;
        dbus_o  = rd_data_sel ? data_out : status;
    end

    assert_bus_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && dack_n) |-> !dbus_oe);
    assert_drq_exec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        drq |-> (phase == PH_EXEC && !status[SB_EXM]));
endmodule

// File: tb/sim_fdc_host_if.sv
module sim_fdc_host_if;
    localparam int BT = 40;
    localparam int RW = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0, dack_n = 1'b1, tc = 1'b0;
    logic [7:0] dbus_i = '0;
    logic [7:0] dbus_o;
    logic dbus_oe, drq, irq;
    logic drv_ready = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [7:0] v;

    always #4 clk = ~clk;

    fdc_host_if #(.BYTE_TIME(BT), .READY_WAIT(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .a0(a0), .dack_n(dack_n), .tc(tc), .dbus_i(dbus_i), .dbus_o(dbus_o),
        .dbus_oe(dbus_oe), .drq(drq), .irq(irq), .drv_ready(drv_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_rd(input logic sel, input logic tcv, output logic [7:0] r);
        @(negedge clk); cs_n = 1'b0; a0 = sel; rd_n = 1'b0; tc = tcv;
        @(negedge clk); r = dbus_o; rd_n = 1'b1; cs_n = 1'b1; tc = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic host_wr(input logic sel, input logic tcv, input logic [7:0] b);
        @(negedge clk); cs_n = 1'b0; a0 = sel; wr_n = 1'b0; tc = tcv; dbus_i = b;
        @(negedge clk); wr_n = 1'b1; cs_n = 1'b1; tc = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic dma_rd(input logic tcv, output logic [7:0] r);
        @(negedge clk); dack_n = 1'b0; a0 = 1'b0; rd_n = 1'b0; tc = tcv;
        @(negedge clk); r = dbus_o; rd_n = 1'b1; dack_n = 1'b1; tc = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic dma_wr(input logic tcv, input logic [7:0] b);
        @(negedge clk); dack_n = 1'b0; a0 = 1'b0; wr_n = 1'b0; tc = tcv; dbus_i = b;
        @(negedge clk); wr_n = 1'b1; dack_n = 1'b1; tc = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic wait_rqm(output logic [7:0] s);
        s = '0;
        for (int i = 0; i < 60; i++) begin
            host_rd(1'b0, 1'b0, s);
            if (s[7]) break;
        end
    endtask

    task automatic wait_drq();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (drq) break;
        end
    endtask

    task automatic results(input string req, input logic [7:0] e0, input logic [7:0] e1,
                           input logic [7:0] ec, input logic [7:0] es);
        logic [7:0] r;
        host_rd(1'b1, 1'b0, r); chk({req, " R8 ST0"}, r, e0);
        chk("R10 irq cleared by first result read", irq, 1'b0);
        host_rd(1'b1, 1'b0, r); chk({req, " R8 ST1"}, r, e1);
        host_rd(1'b1, 1'b0, r); chk({req, " R8 count"}, r, ec);
        host_rd(1'b1, 1'b0, r); chk({req, " R8 xor sum"}, r, es);
        host_rd(1'b0, 1'b0, r); chk("R8 idle after results", r, 8'h80);
    endtask

    task automatic run_xfer(input logic dma, input logic dir, input int n, input int tc_at);
        logic [7:0] s, r, b;
        int taken;
        s = '0; taken = 0;
        host_wr(1'b1, 1'b0, {dir, dma, 6'h05});
        host_wr(1'b1, 1'b0, 8'(n - 1));
        host_rd(1'b0, 1'b0, r);
        chk("R1 status at execution start", r, {1'b0, dir, ~dma, 1'b1, 4'h0});
        for (int k = 0; k < n; k++) begin
            b = 8'h30 + 8'(k * 7);
            if (dma) begin
                wait_drq();
                chk("R3 drq for waiting byte", drq, 1'b1);
                chk("R10 no irq in DMA execution", irq, 1'b0);
                if (dir) begin
                    dma_rd(k == tc_at, r);
                    chk("R4 disk byte value", r, 8'(k) ^ 8'hA5);
                    s = s ^ r;
                end else begin
                    dma_wr(k == tc_at, b);
                    s = s ^ b;
                end
            end else begin
                wait_rqm(r);
                chk("R1 status with byte waiting", r, {1'b1, dir, 1'b1, 1'b1, 4'h0});
                chk("R10 irq per byte", irq, 1'b1);
                if (dir) begin
                    host_rd(1'b1, k == tc_at, r);
                    chk("R4 disk byte value", r, 8'(k) ^ 8'hA5);
                    s = s ^ r;
                end else begin
                    host_wr(1'b1, k == tc_at, b);
                    s = s ^ b;
                end
            end
            taken = k + 1;
            if (k == tc_at) break;
        end
        host_rd(1'b0, 1'b0, r);
        chk("R8 result status", r, 8'hD0);
        chk("R10 irq at command end", irq, 1'b1);
        chk("R9 drq low in result", drq, 1'b0);
        results(tc_at >= 0 ? "R6 tc" : "R8 sweep", 8'h00, 8'h00, 8'(taken), s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        chk("R11 irq after reset", irq, 1'b0);
        chk("R11 drq after reset", drq, 1'b0);
        chk("R11 oe after reset", dbus_oe, 1'b0);
        repeat (RW - 3) @(negedge clk);
        chk("R11 ready irq not yet", irq, 1'b0);
        repeat (5) @(negedge clk);
        chk("R11 ready irq raised", irq, 1'b1);
        host_rd(1'b0, 1'b0, v); chk("R11 R1 idle status", v, 8'h80);

        // R2 bus drive qualification
        @(negedge clk); rd_n = 1'b0;
        @(negedge clk); chk("R2 no drive without select", dbus_oe, 1'b0);
        cs_n = 1'b0;
        @(negedge clk); chk("R2 drive with select", dbus_oe, 1'b1);
        rd_n = 1'b1; cs_n = 1'b1;
        repeat (2) @(negedge clk);

        // R11 sense command
        host_wr(1'b1, 1'b0, 8'h08);
        chk("R11 sense clears irq", irq, 1'b0);
        host_rd(1'b0, 1'b0, v); chk("R8 status in sense result", v, 8'hD0);
        results("R11 sense pending", 8'hC0, 8'h00, 8'h00, 8'h00);
        host_wr(1'b1, 1'b0, 8'h08);
        results("R11 sense idle", 8'h80, 8'h00, 8'h00, 8'h00);

        // R2 ignored writes
        host_wr(1'b0, 1'b0, 8'h45);
        host_rd(1'b0, 1'b0, v); chk("R2 status write ignored", v, 8'h80);
        @(negedge clk); wr_n = 1'b0; a0 = 1'b1; dbus_i = 8'h45;
        @(negedge clk); wr_n = 1'b1;
        repeat (2) @(negedge clk);
        host_rd(1'b0, 1'b0, v); chk("R2 unselected write ignored", v, 8'h80);

        // R5 pacing of first DMA request
        host_wr(1'b1, 1'b0, 8'h45);
        host_wr(1'b1, 1'b0, 8'h00);
        repeat (BT - 2) @(negedge clk);
        chk("R5 drq not before byte time", drq, 1'b0);
        @(negedge clk);
        chk("R5 drq at byte time", drq, 1'b1);
        dma_wr(1'b0, 8'h77);
        results("R5 single write", 8'h00, 8'h00, 8'h01, 8'h77);

        // sweep of modes, directions and lengths
        for (int m = 0; m < 2; m++)
            for (int d = 0; d < 2; d++)
                for (int n = 1; n <= 4; n++)
                    run_xfer(m[0], d[0], n, -1);

        // R6 terminal count
        run_xfer(1'b1, 1'b1, 5, 2);
        run_xfer(1'b0, 1'b0, 4, 1);

        // R7 overrun on first byte, interrupt mode read
        host_wr(1'b1, 1'b0, 8'h85);
        host_wr(1'b1, 1'b0, 8'h02);
        repeat (2 * BT + 4) @(negedge clk);
        host_rd(1'b0, 1'b0, v); chk("R7 abort to result", v, 8'hD0);
        chk("R10 irq on abort", irq, 1'b1);
        results("R7 first byte", 8'h40, 8'h10, 8'h00, 8'h00);

        // R7 R9 overrun on final byte, DMA read, no acknowledge
        host_wr(1'b1, 1'b0, 8'hC5);
        host_wr(1'b1, 1'b0, 8'h01);
        wait_drq();
        dma_rd(1'b0, v); chk("R4 first DMA byte", v, 8'hA5);
        repeat (2 * BT + 4) @(negedge clk);
        chk("R9 drq withdrawn without dack", drq, 1'b0);
        results("R7 final byte", 8'h40, 8'h10, 8'h01, 8'hA5);

        // R7 R9 DMA write starved on its only byte
        host_wr(1'b1, 1'b0, 8'h45);
        host_wr(1'b1, 1'b0, 8'h00);
        wait_drq();
        chk("R3 drq write request", drq, 1'b1);
        repeat (BT + 6) @(negedge clk);
        chk("R9 drq withdrawn write", drq, 1'b0);
        results("R7 write final", 8'h40, 8'h10, 8'h00, 8'h00);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule